// File: doc/BRIEF.md
# SPI Bus Monitor Decoder

This block listens to an SPI bus without driving it. It watches the serial clock, up to two data lines and an optional enable line. It rebuilds the bits on each line into words and presents them to the system side. The bus pins are treated as asynchronous. Each one passes through a two-flop synchronizer in the system clock domain, and clock edges are found by comparing successive synchronized samples. For this reason the bus clock may run at no more than one quarter of the system clock rate.

Software-style settings arrive as static inputs:

- clock idle level and sampling phase
- bit order
- word length, given as length minus one (a typical setting is 7, for 8-bit words)
- enable polarity
- whether the enable line is used
- whether each data line is used

When the enable line is used, it frames every word: the bit count restarts each time the enable becomes active. A word that the enable cuts short is discarded and reported. When the enable line is not used, a start pulse from the system side sets the word boundary. This lets a capture that began in the middle of a word, or that saw spurious clock edges, be realigned.

The block also checks the idle clock level each time the enable becomes active. If that level disagrees with the configured idle polarity, it raises a sticky settings-error flag.

Top module: `spi_mon_decoder`

## Requirements
- R1: When the last bit of a word is sampled, `word_valid` is high for exactly one system clock cycle, and `mosi_word`/`miso_word` carry the completed words while it is high.
- R2: The word length is `cfg_len_m1 + 1` bits, any value from 1 to MAX_BITS (64 by default).
- R3: With `cfg_lsb_first = 0` the first bit on the wire lands in bit position length-1 of the word. With `cfg_lsb_first = 1` it lands in bit 0. Bits above the word length read as zero.
- R4: The leading edge departs the idle level `cfg_cpol`: it is rising for `cfg_cpol = 0` and falling for `cfg_cpol = 1`. With `cfg_cpha = 0` data is sampled on leading edges; with `cfg_cpha = 1` it is sampled on trailing edges.
- R5: With `cfg_use_en = 1`, the enable is active when `bus_en` equals `cfg_en_high` (0 means active low). Clock edges while the enable is inactive produce no word. The bit count restarts each time the enable becomes active.
- R6: A data line whose use bit (`cfg_use_mosi`, `cfg_use_miso`) is 0 reads as an all-zero word.
- R7: If the enable goes inactive after 1 to length-1 bits of a word, those bits are dropped. No `word_valid` is raised, and `partial_drop` pulses high for one cycle.
- R8: When the enable becomes active while the synchronized clock level differs from `cfg_cpol`, `polarity_err` is set. It stays set until `err_clear` is high. A new mismatch in the same cycle as a clear takes precedence.
- R9: With `cfg_use_en = 0`, every sampling edge is used, and an `align_start` pulse restarts the bit count at zero, discarding any partial word.
- R10: After reset, `word_valid`, `partial_drop`, `polarity_err`, `mosi_word` and `miso_word` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Idle level of the bus clock |
| cfg_cpha | input | 1 | 0: sample on leading edges, 1: on trailing edges |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_len_m1 | input | $clog2(MAX_BITS) | Word length minus one |
| cfg_use_en | input | 1 | 1: the enable line frames words |
| cfg_en_high | input | 1 | 1: enable is active high |
| cfg_use_mosi | input | 1 | 1: decode the MOSI line |
| cfg_use_miso | input | 1 | 1: decode the MISO line |
| bus_sck | input | 1 | Bus serial clock (asynchronous) |
| bus_mosi | input | 1 | Bus data, controller to peripheral |
| bus_miso | input | 1 | Bus data, peripheral to controller |
| bus_en | input | 1 | Bus enable / chip select |
| align_start | input | 1 | Word alignment pulse, used when the enable is unused |
| err_clear | input | 1 | Clears the settings-error flag |
| word_valid | output | 1 | One-cycle strobe for a completed word |
| mosi_word | output | MAX_BITS | Word assembled from MOSI |
| miso_word | output | MAX_BITS | Word assembled from MISO |
| partial_drop | output | 1 | One-cycle pulse when a partial word is dropped |
| polarity_err | output | 1 | Sticky clock-polarity settings error |

## Verification
The following properties hold cycle by cycle, and the assertions check them on every cycle:

- `word_valid` and `partial_drop` are single-cycle strobes that never coincide.
- No word appears while the enable is used and inactive.
- `partial_drop` never fires with the enable unused.
- The error flag holds until it is cleared, and it only rises with the enable in use.

Other behaviour only the directed scenarios can show, because it depends on a whole bus transfer:

- that the assembled words match the transmitted bits for every clock mode and both bit orders
- the 1-bit and 64-bit word lengths
- that disabled lanes read zero
- that a cut-short word is dropped and the next one is still aligned
- that a start pulse realigns a stream polluted by stray clock edges

// File: rtl/spi_mon_pkg.sv
package spi_mon_pkg;

   localparam int unsigned MAX_WORD_LIMIT = 64;

   // events produced by the bus front end for one system clock cycle
   typedef struct packed {
      logic samp;      // a sampling edge occurred, data bits are valid
      logic restart;   // bit counter returns to zero
      logic stop;      // enable went inactive
      logic mismatch;  // idle clock level disagrees with polarity setting
   } bus_evt_t;

   // sampling edge is rising when polarity and phase agree, falling otherwise
   function automatic logic samp_on_fall(input logic cpol, input logic cpha);
      return cpol ^ cpha;
   endfunction

endpackage

// File: rtl/spi_mon_sync.sv
module spi_mon_sync #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] d_sync
);

   generate
      if (STAGES < 2) begin : g_bad
         $error("spi_mon_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain[s] <= '0;
            end else begin
               chain[s] <= (s == 0) ? d_async : chain[(s == 0) ? 0 : s-1];
            end
         end
      end
   endgenerate

   assign d_sync = chain[STAGES-1];

endmodule

// File: rtl/spi_mon_front.sv
module spi_mon_front
   import spi_mon_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     cfg_cpol,
   input  logic     cfg_cpha,
   input  logic     cfg_use_en,
   input  logic     cfg_en_high,
   input  logic     align_start,
   input  logic     bus_sck,
   input  logic     bus_mosi,
   input  logic     bus_miso,
   input  logic     bus_en,
   output bus_evt_t evt,
   output logic     en_live,
   output logic     bit_mosi,
   output logic     bit_miso
);

   localparam int unsigned PRIME_W = $clog2(SYNC_STAGES + 2);
   localparam logic [PRIME_W-1:0] PRIME_END = PRIME_W'(SYNC_STAGES + 1);

   logic [3:0] raw_in;
   logic [3:0] syn;
   logic       s_sck, s_en;
   logic       sck_q, en_q;
   logic [PRIME_W-1:0] prime_cnt;
   logic       primed;
   logic       rise, fall, edge_hit;
   logic       en_rise, en_fall;

   assign raw_in = {bus_en, bus_miso, bus_mosi, bus_sck};

   spi_mon_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (raw_in),
      .d_sync  (syn)
   );

   assign s_sck    = syn[0];
   assign bit_mosi = syn[1];
   assign bit_miso = syn[2];
   assign s_en     = syn[3];

   // history registers; events are held off until the synchronizer holds real samples
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q     <= 1'b0;
         en_q      <= 1'b0;
         prime_cnt <= '0;
      end else begin
         sck_q <= s_sck;
         en_q  <= en_live;
         if (!primed) prime_cnt <= prime_cnt + 1'b1;
      end
   end

   assign primed   = (prime_cnt == PRIME_END);
   assign en_live  = cfg_use_en ? (s_en == cfg_en_high) : 1'b1;
   assign rise     = primed & s_sck & ~sck_q;
   assign fall     = primed & ~s_sck & sck_q;
   assign edge_hit = samp_on_fall(cfg_cpol, cfg_cpha) ? fall : rise;
   assign en_rise  = primed & cfg_use_en & en_live & ~en_q;
   assign en_fall  = primed & cfg_use_en & ~en_live & en_q;

   always_comb begin
      evt.samp     = edge_hit & en_live;
      evt.restart  = cfg_use_en ? en_rise : align_start;
      evt.stop     = en_fall;
      evt.mismatch = en_rise & (s_sck != cfg_cpol);
   end

endmodule

// File: rtl/spi_mon_ctrl.sv
module spi_mon_ctrl
   import spi_mon_pkg::*;
#(
   parameter int unsigned MAX_BITS = 64,
   localparam int unsigned CW = $clog2(MAX_BITS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  bus_evt_t      evt,
   input  logic [CW-1:0] cfg_len_m1,
   input  logic          err_clear,
   output logic [CW-1:0] bit_cnt,
   output logic          take_bit,
   output logic          word_done,
   output logic          word_valid,
   output logic          partial_drop,
   output logic          polarity_err
);

   // restart and stop outrank a sample in the same cycle
   assign take_bit  = evt.samp & ~evt.restart & ~evt.stop;
   assign word_done = take_bit & (bit_cnt == cfg_len_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt      <= '0;
         word_valid   <= 1'b0;
         partial_drop <= 1'b0;
      end else begin
         word_valid   <= 1'b0;
         partial_drop <= 1'b0;
         if (evt.restart) begin
            bit_cnt <= '0;
         end else if (evt.stop) begin
            partial_drop <= (bit_cnt != '0);
            bit_cnt      <= '0;
         end else if (take_bit) begin
            if (word_done) begin
               bit_cnt    <= '0;
               word_valid <= 1'b1;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         polarity_err <= 1'b0;
      end else if (evt.mismatch) begin
         polarity_err <= 1'b1;
      end else if (err_clear) begin
         polarity_err <= 1'b0;
      end
   end

endmodule

// File: rtl/spi_mon_lane.sv
module spi_mon_lane #(
   parameter int unsigned MAX_BITS = 64,
   localparam int unsigned CW = $clog2(MAX_BITS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                lane_on,
   input  logic                lsb_first,
   input  logic                take_bit,
   input  logic                word_done,
   input  logic [CW-1:0]       bit_cnt,
   input  logic                din,
   output logic [MAX_BITS-1:0] word
);

   logic [MAX_BITS-1:0] acc, base, acc_next;

   // first bit of a word starts from a clean accumulator
   assign base = (bit_cnt == '0) ? '0 : acc;

   always_comb begin
      if (lsb_first) acc_next = base | (MAX_BITS'(din) << bit_cnt);
      else           acc_next = {base[MAX_BITS-2:0], din};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc  <= '0;
         word <= '0;
      end else begin
         if (take_bit) acc <= acc_next;
         if (word_done) word <= lane_on ? acc_next : '0;
      end
   end

endmodule

// File: rtl/spi_mon_decoder.sv
module spi_mon_decoder
   import spi_mon_pkg::*;
#(
   parameter int unsigned MAX_BITS    = 64,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned CW = $clog2(MAX_BITS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_cpol,
   input  logic                cfg_cpha,
   input  logic                cfg_lsb_first,
   input  logic [CW-1:0]       cfg_len_m1,
   input  logic                cfg_use_en,
   input  logic                cfg_en_high,
   input  logic                cfg_use_mosi,
   input  logic                cfg_use_miso,
   input  logic                bus_sck,
   input  logic                bus_mosi,
   input  logic                bus_miso,
   input  logic                bus_en,
   input  logic                align_start,
   input  logic                err_clear,
   output logic                word_valid,
   output logic [MAX_BITS-1:0] mosi_word,
   output logic [MAX_BITS-1:0] miso_word,
   output logic                partial_drop,
   output logic                polarity_err
);

   generate
      if (MAX_BITS < 2 || MAX_BITS > MAX_WORD_LIMIT) begin : g_bad_bits
         $error("spi_mon_decoder: MAX_BITS must lie in 2..64");
      end
   endgenerate

   bus_evt_t      evt;
   logic          en_live;
   logic          bit_mosi, bit_miso;
   logic [CW-1:0] bit_cnt;
   logic          take_bit, word_done;

   spi_mon_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_cpol    (cfg_cpol),
      .cfg_cpha    (cfg_cpha),
      .cfg_use_en  (cfg_use_en),
      .cfg_en_high (cfg_en_high),
      .align_start (align_start),
      .bus_sck     (bus_sck),
      .bus_mosi    (bus_mosi),
      .bus_miso    (bus_miso),
      .bus_en      (bus_en),
      .evt         (evt),
      .en_live     (en_live),
      .bit_mosi    (bit_mosi),
      .bit_miso    (bit_miso)
   );

   spi_mon_ctrl #(.MAX_BITS(MAX_BITS)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .evt          (evt),
      .cfg_len_m1   (cfg_len_m1),
      .err_clear    (err_clear),
      .bit_cnt      (bit_cnt),
      .take_bit     (take_bit),
      .word_done    (word_done),
      .word_valid   (word_valid),
      .partial_drop (partial_drop),
      .polarity_err (polarity_err)
   );

   logic [1:0]          lane_bit, lane_on;
   logic [MAX_BITS-1:0] lane_word [2];

   assign lane_bit = {bit_miso, bit_mosi};
   assign lane_on  = {cfg_use_miso, cfg_use_mosi};

   generate
      for (genvar g = 0; g < 2; g++) begin : g_lane
         spi_mon_lane #(.MAX_BITS(MAX_BITS)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .lane_on   (lane_on[g]),
            .lsb_first (cfg_lsb_first),
            .take_bit  (take_bit),
            .word_done (word_done),
            .bit_cnt   (bit_cnt),
            .din       (lane_bit[g]),
            .word      (lane_word[g])
         );
      end
   endgenerate

   assign mosi_word = lane_word[0];
   assign miso_word = lane_word[1];

endmodule

// File: rtl/spi_mon_checker.sv
module spi_mon_checker (
   input logic clk,
   input logic rst_n,
   input logic cfg_use_en,
   input logic en_live,
   input logic err_clear,
   input logic word_valid,
   input logic partial_drop,
   input logic polarity_err
);

   // R1
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |=> !word_valid);

   // R5
   gated_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_use_en && !en_live) |=> !word_valid);

   // R7
   drop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      partial_drop |-> !word_valid);

   // R7
   drop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      partial_drop |=> !partial_drop);

   // R8
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (polarity_err && !err_clear) |=> polarity_err);

   // R8
   err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(polarity_err) |-> $past(cfg_use_en));

   // R9
   no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_use_en |=> !partial_drop);

endmodule

bind spi_mon_decoder spi_mon_checker u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_use_en   (cfg_use_en),
   .en_live      (en_live),
   .err_clear    (err_clear),
   .word_valid   (word_valid),
   .partial_drop (partial_drop),
   .polarity_err (polarity_err)
);

// File: tb/sim_spi_mon_decoder.sv
`timescale 1ns/1ps
module sim_spi_mon_decoder;

   localparam int MB = 64;
   localparam int CW = $clog2(MB);
   localparam int HALF = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_cpol = 0, cfg_cpha = 0, cfg_lsb_first = 0;
   logic [CW-1:0] cfg_len_m1 = CW'(7);
   logic cfg_use_en = 1, cfg_en_high = 0, cfg_use_mosi = 1, cfg_use_miso = 1;
   logic bus_sck = 0, bus_mosi = 0, bus_miso = 0, bus_en = 1;
   logic align_start = 0, err_clear = 0;
   logic word_valid, partial_drop, polarity_err;
   logic [MB-1:0] mosi_word, miso_word;

   always #2.5 clk = ~clk;

   spi_mon_decoder #(.MAX_BITS(MB)) u0 (.*);

   int n_chk = 0, n_bad = 0;
   int vcount = 0, pcount = 0;
   logic [MB-1:0] last_mo = '0, last_mi = '0;
   bit done = 0;

   always @(negedge clk) begin
      if (rst_n && word_valid) begin
         vcount++;
         last_mo = mosi_word;
         last_mi = miso_word;
      end
      if (rst_n && partial_drop) pcount++;
   end

   task automatic check(input string req, input logic [MB-1:0] act, input logic [MB-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   function automatic logic [MB-1:0] mask(input int n);
      return (n >= MB) ? '1 : ((64'd1 << n) - 64'd1);
   endfunction

   task automatic en_set(input bit act);
      bus_en = act ? cfg_en_high : ~cfg_en_high;
   endtask

   // drives n bits of each pattern on the bus with the current settings
   task automatic shift_bits(input logic [MB-1:0] mo, input logic [MB-1:0] mi, input int n, input bit msb);
      for (int i = 0; i < n; i++) begin
         int idx = msb ? n-1-i : i;
         if (!cfg_cpha) begin
            bus_mosi = mo[idx]; bus_miso = mi[idx];
            tick(HALF); bus_sck = ~cfg_cpol;
            tick(HALF); bus_sck = cfg_cpol;
         end else begin
            bus_sck = ~cfg_cpol; bus_mosi = mo[idx]; bus_miso = mi[idx];
            tick(HALF); bus_sck = cfg_cpol;
            tick(HALF);
         end
      end
      tick(HALF);
   endtask

   task automatic frame(input logic [MB-1:0] mo, input logic [MB-1:0] mi, input int n);
      cfg_len_m1 = CW'(n-1);
      bus_sck = cfg_cpol;
      tick(6);
      vcount = 0; pcount = 0;
      en_set(1); tick(HALF);
      shift_bits(mo, mi, n, !cfg_lsb_first);
      en_set(0); tick(8);
   endtask

   task automatic t_reset;
      check("R10 valid", MB'(word_valid), '0);
      check("R10 drop", MB'(partial_drop), '0);
      check("R10 err", MB'(polarity_err), '0);
      check("R10 mosi", mosi_word, '0);
      check("R10 miso", miso_word, '0);
   endtask

   task automatic t_modes;
      for (int m = 0; m < 4; m++) begin
         logic [MB-1:0] mo = MB'(8'hA5 ^ (m * 8'h11));
         logic [MB-1:0] mi = MB'(8'h3C + m);
         cfg_cpol = m[1]; cfg_cpha = m[0]; cfg_lsb_first = m[0];
         frame(mo, mi, 8);
         check("R1 R4 count", MB'(vcount), 1);
         check("R3 R4 mosi", last_mo, mo);
         check("R3 R4 miso", last_mi, mi);
      end
      cfg_cpol = 0; cfg_cpha = 0; cfg_lsb_first = 0; bus_sck = 0;
   endtask

   task automatic t_len;
      logic [MB-1:0] big = 64'hF00D_5A5A_1234_C3E7;
      frame(64'h1, 64'h0, 1);
      check("R2 len1 mosi", last_mo, 64'h1);
      check("R2 len1 count", MB'(vcount), 1);
      frame(big, ~big, 64);
      check("R2 len64 mosi", last_mo, big);
      check("R2 len64 miso", last_mi, ~big);
      cfg_lsb_first = 1;
      frame(big & mask(13), 64'h1ABC, 13);
      check("R3 len13 lsb mosi", last_mo, big & mask(13));
      check("R3 len13 lsb miso", last_mi, 64'h1ABC & mask(13));
      cfg_lsb_first = 0;
   endtask

   task automatic t_lane_off;
      cfg_use_miso = 0;
      frame(64'h5E, 64'hFF, 8);
      check("R6 miso off", last_mi, '0);
      check("R6 mosi on", last_mo, 64'h5E);
      cfg_use_miso = 1; cfg_use_mosi = 0;
      frame(64'hFF, 64'h81, 8);
      check("R6 mosi off", last_mo, '0);
      check("R6 miso on", last_mi, 64'h81);
      cfg_use_mosi = 1;
   endtask

   task automatic t_en_pol;
      cfg_en_high = 1;
      frame(64'hC9, 64'h27, 8);
      check("R5 active high", last_mo, 64'hC9);
      // enable held inactive: clock activity must produce nothing
      en_set(0); tick(6);
      vcount = 0;
      shift_bits(64'hFF, 64'hFF, 8, 1);
      tick(6);
      check("R5 inactive ignored", MB'(vcount), 0);
      cfg_en_high = 0; en_set(0); tick(6);
   endtask

   task automatic t_partial;
      cfg_len_m1 = CW'(7);
      tick(6);
      vcount = 0; pcount = 0;
      en_set(1); tick(HALF);
      shift_bits(64'h1F, 64'h00, 5, 1);
      en_set(0); tick(8);
      check("R7 drop pulse", MB'(pcount), 1);
      check("R7 no word", MB'(vcount), 0);
      frame(64'h96, 64'h69, 8);
      check("R7 realigned", last_mo, 64'h96);
      check("R7 no drop on full", MB'(pcount), 0);
   endtask

   task automatic t_polerr;
      cfg_cpol = 1; bus_sck = 0;
      tick(6);
      en_set(1); tick(6);
      check("R8 set", MB'(polarity_err), 1);
      en_set(0); tick(6);
      check("R8 sticky", MB'(polarity_err), 1);
      err_clear = 1; tick(1); err_clear = 0; tick(2);
      check("R8 cleared", MB'(polarity_err), 0);
      cfg_cpol = 0; tick(4);
      en_set(1); tick(6); en_set(0); tick(6);
      check("R8 matched idle", MB'(polarity_err), 0);
   endtask

   task automatic t_noen;
      cfg_use_en = 0; cfg_len_m1 = CW'(7);
      tick(6);
      vcount = 0; pcount = 0;
      shift_bits(64'h7, 64'h0, 3, 1);
      check("R9 stray no word", MB'(vcount), 0);
      align_start = 1; tick(1); align_start = 0; tick(2);
      shift_bits(64'hB4, 64'h4B, 8, 1);
      tick(4);
      check("R9 aligned count", MB'(vcount), 1);
      check("R9 aligned mosi", last_mo, 64'hB4);
      check("R9 aligned miso", last_mi, 64'h4B);
      check("R9 no drop", MB'(pcount), 0);
      cfg_use_en = 1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL WDOG: actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      tick(5);
      rst_n = 1'b1;
      tick(1);
      t_reset();
      tick(6);
      t_modes();
      t_len();
      t_lane_off();
      t_en_pol();
      t_partial();
      t_polerr();
      t_noen();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule